// File: doc/BRIEF.md
# I2C Event Flags and Byte-Count Completion Unit

This unit keeps the event flags of an I2C controller and decides, flag by flag, when each one is raised and when it drops. A separate bus engine sends it single-cycle pulses: a received byte that is ready to be handed to software, a NACK that was sampled, a slave address hit, a STOP seen on the bus, and a START or STOP that came at the wrong point in a frame. Each flag has its own clearing rule. Some clear through a write-one strobe. Others clear when the byte count is rewritten, when START or STOP is requested, or when the data register is read. A low peripheral enable also clears some of them.

The unit also counts the bytes of a segment against a programmable 8-bit byte number. When the count runs out, the reload and automatic-end modes decide what happens: a reload-complete flag is raised, a transfer-complete flag is raised, or a STOP request goes to the bus engine. Software reaches the unit through a small word-wide register port. The flag vector is also presented directly on a port so that an interrupt controller can use it.

Top module: `i2c_evt_status`

## Requirements
- R1: After reset, every flag is 0, the read-data register holds 0, RELOAD, AUTOEND and the byte number are 0, the internal counter is 0, and start_req and stop_req are low.
- R2: reg_rdata follows reg_addr in the same cycle. Address 0 reads RELOAD at bit 0 and AUTOEND at bit 1, and bits 2 and 3 (the START and STOP strobes) read as 0. Address 1 reads the byte number in bits 7:0. Address 2 reads the flags: bus error 8, reload-complete 7, transfer-complete 6, STOP-seen 5, NACK 4, address-hit 3, receive-full 2. Address 3 reads the last received byte in bits 7:0. Every other bit reads 0, and the flags port carries the same 9-bit flag word.
- R3: The bus-error flag goes to 1 the cycle after ev_misplaced. It goes to 0 when bit 8 is written as 1 at address 2. It is held at 0 while per_en is low.
- R4: The STOP-seen, NACK and address-hit flags each go to 1 after their own event pulse. Writing 1 to bit 5, 4 or 3 at address 2 clears only the matching flag. All three are held at 0 while per_en is low.
- R5: ev_rx_valid stores ev_rx_data into the read-data register and sets receive-full. A read at address 3 clears receive-full. Reads at other addresses leave it unchanged.
- R6: A write of a nonzero value to address 1 loads the counter with that value. A START request loads the counter with the stored byte number. A write of zero only stores the byte number. Each ev_byte_done decrements a nonzero counter. A step from 1 to 0 is a completion. ev_byte_done with the counter at 0 has no effect.
- R7: A completion with RELOAD=1 sets reload-complete. Only a nonzero write to address 1 clears it. A zero write, a START request and a STOP request leave it set.
- R8: A completion with RELOAD=0 and AUTOEND=0 sets transfer-complete. Writing address 0 with bit 2 (START) or bit 3 (STOP) set clears it.
- R9: A completion with RELOAD=0 and AUTOEND=1 drives stop_req high in the next cycle and leaves transfer-complete at 0.
- R10: A write to address 0 with bit 2 set drives start_req high for the next cycle. With bit 3 set, stop_req goes high for the next cycle. Writes to address 0 also store RELOAD (bit 0) and AUTOEND (bit 1).
- R11: When a set event and a software clear of the same flag arrive in the same cycle, the flag ends at 1.
- R12: When per_en is low, the bus-error, STOP-seen, NACK and address-hit flags are 0 in the next cycle, even if a set event arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| per_en | input | 1 | Peripheral enable; low holds the bus-event flags at 0 |
| ev_misplaced | input | 1 | START or STOP seen at an illegal point |
| ev_stop_seen | input | 1 | STOP condition seen on the bus |
| ev_nack | input | 1 | NACK sampled in the acknowledge slot |
| ev_addr_hit | input | 1 | Received slave address matched an enabled address |
| ev_rx_valid | input | 1 | A received byte is ready on ev_rx_data |
| ev_rx_data | input | DATA_W (8) | Received byte |
| ev_byte_done | input | 1 | One byte of the segment has completed |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | REG_DW (32) | Register write data |
| reg_rdata | output | REG_DW (32) | Register read data, combinational from reg_addr |
| flags | output | 9 | Flag word, same layout as address 2 |
| start_req | output | 1 | One-cycle START request to the bus engine |
| stop_req | output | 1 | One-cycle STOP request to the bus engine |

## Verification
Each flag is a single register bit, so a wrong set, clear or priority decision shows on the flags port one cycle after the stimulus. The counter is hidden, and a miscount only shows at completion time. A completion flag or stop_req then appears one byte early or one byte late, or does not appear at all. For this reason the bench runs segments of 1 to 3 bytes under every RELOAD and AUTOEND mix, with counter loads landing between bytes and on top of them. A wrong mode decision shows in the same cycle: the wrong one of reload-complete, transfer-complete and stop_req is raised.

// File: rtl/i2c_evt_pkg.sv
// Shared constants and types for the I2C event flag unit.
// Assumes a 9-bit flag word and a 4-entry register window.
package i2c_evt_pkg;

    localparam int STAT_W = 9;

    // Flag positions inside the flag word (software decodes these)
    localparam int F_RBNE = 2;
    localparam int F_ADDR = 3;
    localparam int F_NACK = 4;
    localparam int F_STP  = 5;
    localparam int F_TC   = 6;
    localparam int F_TCR  = 7;
    localparam int F_BERR = 8;

    // Control word bit positions at address 0
    localparam int C_RELOAD  = 0;
    localparam int C_AUTOEND = 1;
    localparam int C_START   = 2;
    localparam int C_STOP    = 3;

    // Flags cleared by write-one strobes, in bank order
    localparam int NW1C = 4;
    localparam int W1C_POS [NW1C] = '{F_BERR, F_STP, F_NACK, F_ADDR};

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_COUNT = 2'd1,
        RA_STAT  = 2'd2,
        RA_RDATA = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic reload_done;
        logic xfer_done;
        logic auto_stop;
    } cmpl_t;

endpackage

// File: rtl/i2c_evt_flag_cell.sv
// One sticky flag bit: kill beats set, set beats clear.
// Assumes all inputs are synchronous single-cycle strobes.
module i2c_evt_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic kill,
    output logic q
);

    // Holds the flag with the fixed priority kill > set > clear
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 1'b0;
        else if (kill) q <= 1'b0;
        else if (set)  q <= 1'b1;
        else if (clr)  q <= 1'b0;
    end

endmodule

// File: rtl/i2c_evt_regif.sv
// Register window: decodes writes into strobes, stores the control
// fields and the byte number, and muxes read data.
// Assumes REG_DW is wide enough to hold the 9-bit flag word.
module i2c_evt_regif
    import i2c_evt_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 8,
    parameter int REG_DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic [STAT_W-1:0] stat_word,
    input  logic [DATA_W-1:0] rx_word,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              reload_q,
    output logic              autoend_q,
    output logic [CNT_W-1:0]  bnum_q,
    output logic              sw_start,
    output logic              sw_stop,
    output logic              cnt_load_nz,
    output logic [CNT_W-1:0]  cnt_load_val,
    output logic [NW1C-1:0]   clr_w1c,
    output logic              rx_pop
);

    reg_sel_e sel;
    logic     wr_ctrl, wr_cnt, wr_stat;
    logic     unused_wd_hi;

    assign sel = reg_sel_e'(reg_addr);

    // Write decode per register
    assign wr_ctrl = reg_wr && (sel == RA_CTRL);
    assign wr_cnt  = reg_wr && (sel == RA_COUNT);
    assign wr_stat = reg_wr && (sel == RA_STAT);

    assign sw_start     = wr_ctrl && reg_wdata[C_START];
    assign sw_stop      = wr_ctrl && reg_wdata[C_STOP];
    assign cnt_load_val = reg_wdata[CNT_W-1:0];
    assign cnt_load_nz  = wr_cnt && (reg_wdata[CNT_W-1:0] != '0);
    assign rx_pop       = reg_rd && (sel == RA_RDATA);
    assign unused_wd_hi = ^reg_wdata[REG_DW-1:STAT_W];

    // Write-one clear strobes routed to the flag bank order
    for (genvar gi = 0; gi < NW1C; gi++) begin : g_clr
        assign clr_w1c[gi] = wr_stat && reg_wdata[W1C_POS[gi]];
    end

    // Stores the mode bits and the programmed byte number
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q  <= 1'b0;
            autoend_q <= 1'b0;
            bnum_q    <= '0;
        end else begin
            if (wr_ctrl) begin
                reload_q  <= reg_wdata[C_RELOAD];
                autoend_q <= reg_wdata[C_AUTOEND];
            end
            if (wr_cnt) bnum_q <= reg_wdata[CNT_W-1:0];
        end
    end

    // Read mux, zero-filling every bit without a field
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            RA_CTRL: begin
                reg_rdata[C_RELOAD]  = reload_q;
                reg_rdata[C_AUTOEND] = autoend_q;
            end
            RA_COUNT: reg_rdata[CNT_W-1:0]  = bnum_q;
            RA_STAT:  reg_rdata[STAT_W-1:0] = stat_word;
            RA_RDATA: reg_rdata[DATA_W-1:0] = rx_word;
        endcase
    end

endmodule

// File: rtl/i2c_evt_xfer_cnt.sv
// Segment byte counter: loads, counts bytes down and turns the step
// from 1 to 0 into one completion pulse that the modes steer.
// Assumes a load and a START request never come in the same cycle.
module i2c_evt_xfer_cnt
    import i2c_evt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_nz,
    input  logic [CNT_W-1:0] load_val,
    input  logic             sw_start,
    input  logic [CNT_W-1:0] bnum,
    input  logic             byte_done,
    input  logic             reload,
    input  logic             autoend,
    output cmpl_t            cmpl
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             last_byte;

    assign last_byte = byte_done && (cnt_q == ONE);

    // Steers the completion pulse by the RELOAD and AUTOEND modes
    always_comb begin
        cmpl.reload_done = last_byte && reload;
        cmpl.xfer_done   = last_byte && !reload && !autoend;
        cmpl.auto_stop   = last_byte && !reload && autoend;
    end

    // Counter: a load wins over a decrement in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (load_nz)                    cnt_q <= load_val;
        else if (sw_start)                   cnt_q <= bnum;
        else if (byte_done && cnt_q != '0)   cnt_q <= cnt_q - ONE;
    end

endmodule

// File: rtl/i2c_evt_flag_bank.sv
// Flag bank: every flag with its own set and clear sources, gathered
// into the 9-bit flag word with the unused positions tied to 0.
// Assumes the event inputs are single-cycle pulses.
module i2c_evt_flag_bank
    import i2c_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              per_en,
    input  logic              ev_misplaced,
    input  logic              ev_stop_seen,
    input  logic              ev_nack,
    input  logic              ev_addr_hit,
    input  logic              ev_rx_valid,
    input  logic [NW1C-1:0]   clr_w1c,
    input  logic              reload_done,
    input  logic              xfer_done,
    input  logic              cnt_load_nz,
    input  logic              sw_start,
    input  logic              sw_stop,
    input  logic              rx_pop,
    output logic [STAT_W-1:0] stat_word
);

    logic [NW1C-1:0] w1c_set, w1c_q;
    logic            tcr_q, tc_q, rbne_q;

    // Event order matches W1C_POS: bus error, STOP, NACK, address
    assign w1c_set = {ev_addr_hit, ev_nack, ev_stop_seen, ev_misplaced};

    for (genvar gi = 0; gi < NW1C; gi++) begin : g_w1c
        i2c_evt_flag_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (w1c_set[gi]),
            .clr  (clr_w1c[gi]),
            .kill (!per_en),
            .q    (w1c_q[gi])
        );
    end

    i2c_evt_flag_cell u_tcr (
        .clk(clk), .rst_n(rst_n), .set(reload_done),
        .clr(cnt_load_nz), .kill(1'b0), .q(tcr_q)
    );

    i2c_evt_flag_cell u_tc (
        .clk(clk), .rst_n(rst_n), .set(xfer_done),
        .clr(sw_start || sw_stop), .kill(1'b0), .q(tc_q)
    );

    i2c_evt_flag_cell u_rbne (
        .clk(clk), .rst_n(rst_n), .set(ev_rx_valid),
        .clr(rx_pop), .kill(1'b0), .q(rbne_q)
    );

    // Gathers the flag word
    always_comb begin
        stat_word         = '0;
        stat_word[F_TCR]  = tcr_q;
        stat_word[F_TC]   = tc_q;
        stat_word[F_RBNE] = rbne_q;
        for (int i = 0; i < NW1C; i++) stat_word[W1C_POS[i]] = w1c_q[i];
    end

endmodule

// File: rtl/i2c_evt_status.sv
// Top of the I2C event flag unit: register window, byte counter,
// flag bank, received-byte holder and the request pulses.
// Assumes a single clock and that the bus engine holds off new events
// while it is disabled.
module i2c_evt_status
    import i2c_evt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    parameter int REG_DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              per_en,
    input  logic              ev_misplaced,
    input  logic              ev_stop_seen,
    input  logic              ev_nack,
    input  logic              ev_addr_hit,
    input  logic              ev_rx_valid,
    input  logic [DATA_W-1:0] ev_rx_data,
    input  logic              ev_byte_done,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic [STAT_W-1:0] flags,
    output logic              start_req,
    output logic              stop_req
);

    logic [DATA_W-1:0] rx_q;
    logic              ctl_reload, ctl_autoend;
    logic [CNT_W-1:0]  bnum;
    logic              sw_start, sw_stop, cnt_load_nz, rx_pop;
    logic [CNT_W-1:0]  cnt_load_val;
    logic [NW1C-1:0]   clr_w1c;
    cmpl_t             cmpl;
    logic [STAT_W-1:0] stat_word;

    i2c_evt_regif #(.CNT_W(CNT_W), .DATA_W(DATA_W), .REG_DW(REG_DW)) u_regif (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .stat_word   (stat_word),
        .rx_word     (rx_q),
        .reg_rdata   (reg_rdata),
        .reload_q    (ctl_reload),
        .autoend_q   (ctl_autoend),
        .bnum_q      (bnum),
        .sw_start    (sw_start),
        .sw_stop     (sw_stop),
        .cnt_load_nz (cnt_load_nz),
        .cnt_load_val(cnt_load_val),
        .clr_w1c     (clr_w1c),
        .rx_pop      (rx_pop)
    );

    i2c_evt_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_nz  (cnt_load_nz),
        .load_val (cnt_load_val),
        .sw_start (sw_start),
        .bnum     (bnum),
        .byte_done(ev_byte_done),
        .reload   (ctl_reload),
        .autoend  (ctl_autoend),
        .cmpl     (cmpl)
    );

    i2c_evt_flag_bank u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .per_en      (per_en),
        .ev_misplaced(ev_misplaced),
        .ev_stop_seen(ev_stop_seen),
        .ev_nack     (ev_nack),
        .ev_addr_hit (ev_addr_hit),
        .ev_rx_valid (ev_rx_valid),
        .clr_w1c     (clr_w1c),
        .reload_done (cmpl.reload_done),
        .xfer_done   (cmpl.xfer_done),
        .cnt_load_nz (cnt_load_nz),
        .sw_start    (sw_start),
        .sw_stop     (sw_stop),
        .rx_pop      (rx_pop),
        .stat_word   (stat_word)
    );

    assign flags = stat_word;

    // Holds the last received byte for software
    always_ff @(posedge clk) begin
        if (!rst_n)           rx_q <= '0;
        else if (ev_rx_valid) rx_q <= ev_rx_data;
    end

    // Registers the request pulses toward the bus engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_req <= 1'b0;
            stop_req  <= 1'b0;
        end else begin
            start_req <= sw_start;
            stop_req  <= sw_stop || cmpl.auto_stop;
        end
    end

endmodule

// File: rtl/i2c_evt_status_chk.sv
// Property checker for the I2C event flag unit, bound to the top.
module i2c_evt_status_chk
    import i2c_evt_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int REG_DW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              per_en,
    input logic              ev_nack,
    input logic              ev_addr_hit,
    input logic              ev_rx_valid,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [REG_DW-1:0] reg_wdata,
    input logic [STAT_W-1:0] flags,
    input logic              start_req,
    input logic              reload_q,
    input logic              autoend_q
);

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !per_en |=> (!flags[F_BERR] && !flags[F_STP] && !flags[F_NACK] && !flags[F_ADDR])); // R12

    AST_NACK_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (per_en && ev_nack) |=> flags[F_NACK]); // R11

    AST_ADDR_HIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (per_en && ev_addr_hit) |=> flags[F_ADDR]); // R4

    AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> $past(reg_wr && reg_addr == 2'd0 && reg_wdata[C_START])); // R10

    AST_TC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[F_TC]) |-> $past(!reload_q && !autoend_q)); // R8

    AST_TCR_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[F_TCR]) |-> $past(reg_wr && reg_addr == 2'd1 && reg_wdata[CNT_W-1:0] != '0)); // R7

    AST_RBNE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[F_RBNE]) |-> $past(ev_rx_valid)); // R5

endmodule

bind i2c_evt_status i2c_evt_status_chk #(.CNT_W(CNT_W), .REG_DW(REG_DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .per_en     (per_en),
    .ev_nack    (ev_nack),
    .ev_addr_hit(ev_addr_hit),
    .ev_rx_valid(ev_rx_valid),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .flags      (flags),
    .start_req  (start_req),
    .reload_q   (ctl_reload),
    .autoend_q  (ctl_autoend)
);

// File: tb/i2c_evt_status_tb_top.sv
// Bench: directed corner cases, then seeded random traffic, all
// compared against a cycle model written from the requirements.
module i2c_evt_status_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        per_en, ev_misplaced, ev_stop_seen, ev_nack, ev_addr_hit;
    logic        ev_rx_valid, ev_byte_done, reg_wr, reg_rd;
    logic [7:0]  ev_rx_data;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [8:0]  flags;
    logic        start_req, stop_req;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Model state
    logic m_berr, m_tcr, m_tc, m_stp, m_nack, m_addr, m_rbne;
    logic m_rl, m_ae, m_start, m_stop;
    logic [7:0] m_cnt, m_bnum, m_rx;

    always #5 clk = ~clk;

    i2c_evt_status dut_i (
        .clk(clk), .rst_n(rst_n), .per_en(per_en),
        .ev_misplaced(ev_misplaced), .ev_stop_seen(ev_stop_seen),
        .ev_nack(ev_nack), .ev_addr_hit(ev_addr_hit),
        .ev_rx_valid(ev_rx_valid), .ev_rx_data(ev_rx_data),
        .ev_byte_done(ev_byte_done), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .flags(flags), .start_req(start_req), .stop_req(stop_req)
    );

    function automatic logic [8:0] m_flags();
        return {m_berr, m_tcr, m_tc, m_stp, m_nack, m_addr, m_rbne, 2'b00};
    endfunction

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return {30'd0, m_ae, m_rl};
            2'd1:    return {24'd0, m_bnum};
            2'd2:    return {23'd0, m_flags()};
            default: return {24'd0, m_rx};
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ev_misplaced = 0; ev_stop_seen = 0; ev_nack = 0; ev_addr_hit = 0;
        ev_rx_valid = 0; ev_rx_data = 8'h00; ev_byte_done = 0;
        reg_wr = 0; reg_rd = 0; reg_addr = 2'd2; reg_wdata = 32'd0;
    endtask

    // One clock: check the read path, advance the model, check the flags
    task automatic step();
        logic wr_ctrl, sw_st, sw_sp, wr_cnt, ld_nz, wr_clr, pop, last;
        logic c_rl, c_tc, c_as;
        #1;
        chk(reg_rdata, m_read(reg_addr), "R2 read path");
        wr_ctrl = reg_wr && reg_addr == 2'd0;
        sw_st   = wr_ctrl && reg_wdata[2];
        sw_sp   = wr_ctrl && reg_wdata[3];
        wr_cnt  = reg_wr && reg_addr == 2'd1;
        ld_nz   = wr_cnt && reg_wdata[7:0] != 8'd0;
        wr_clr  = reg_wr && reg_addr == 2'd2;
        pop     = reg_rd && reg_addr == 2'd3;
        last    = ev_byte_done && m_cnt == 8'd1;
        c_rl    = last && m_rl;
        c_tc    = last && !m_rl && !m_ae;
        c_as    = last && !m_rl && m_ae;
        m_berr  = !per_en ? 1'b0 : ev_misplaced ? 1'b1 : (wr_clr && reg_wdata[8]) ? 1'b0 : m_berr;
        m_stp   = !per_en ? 1'b0 : ev_stop_seen ? 1'b1 : (wr_clr && reg_wdata[5]) ? 1'b0 : m_stp;
        m_nack  = !per_en ? 1'b0 : ev_nack      ? 1'b1 : (wr_clr && reg_wdata[4]) ? 1'b0 : m_nack;
        m_addr  = !per_en ? 1'b0 : ev_addr_hit  ? 1'b1 : (wr_clr && reg_wdata[3]) ? 1'b0 : m_addr;
        m_tcr   = c_rl ? 1'b1 : ld_nz ? 1'b0 : m_tcr;
        m_tc    = c_tc ? 1'b1 : (sw_st || sw_sp) ? 1'b0 : m_tc;
        m_rbne  = ev_rx_valid ? 1'b1 : pop ? 1'b0 : m_rbne;
        if (ev_rx_valid) m_rx = ev_rx_data;
        if (ld_nz) m_cnt = reg_wdata[7:0];
        else if (sw_st) m_cnt = m_bnum;
        else if (ev_byte_done && m_cnt != 8'd0) m_cnt = m_cnt - 8'd1;
        if (wr_cnt) m_bnum = reg_wdata[7:0];
        if (wr_ctrl) begin m_rl = reg_wdata[0]; m_ae = reg_wdata[1]; end
        m_start = sw_st;
        m_stop  = sw_sp || c_as;
        @(posedge clk);
        @(negedge clk);
        chk(32'(flags[8]), 32'(m_berr), "R3 bus error");
        chk(32'(flags[5:3]), 32'({m_stp, m_nack, m_addr}), "R4 stop/nack/addr");
        chk(32'(flags[2]), 32'(m_rbne), "R5 receive full");
        chk(32'(flags[7]), 32'(m_tcr), "R7 reload complete");
        chk(32'(flags[6]), 32'(m_tc), "R8 transfer complete");
        chk(32'(flags[1:0]), 32'd0, "R2 unused bits");
        chk(32'(start_req), 32'(m_start), "R10 start_req");
        chk(32'(stop_req), 32'(m_stop), "R9 stop_req");
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        idle(); reg_wr = 1; reg_addr = a; reg_wdata = d; step(); idle();
    endtask

    task automatic bytes(input int n);
        for (int i = 0; i < n; i++) begin idle(); ev_byte_done = 1; step(); end
        idle();
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        idle();
        per_en = 1; rst_n = 0;
        {m_berr, m_tcr, m_tc, m_stp, m_nack, m_addr, m_rbne} = '0;
        {m_rl, m_ae, m_start, m_stop} = '0;
        m_cnt = 0; m_bnum = 0; m_rx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        #1;
        chk(32'(flags), 32'd0, "R1 flags after reset");
        chk(32'({start_req, stop_req}), 32'd0, "R1 requests after reset");
        reg_addr = 2'd0; #1; chk(reg_rdata, 32'd0, "R1 control after reset");
        reg_addr = 2'd3; #1; chk(reg_rdata, 32'd0, "R1 data after reset");
        idle(); step();

        // R6/R8: three-byte segment, plain mode
        wr(2'd1, 32'd3);
        wr(2'd0, 32'h4);
        bytes(2);
        chk(32'(flags[6]), 32'd0, "R6 no completion before last byte");
        bytes(1);
        chk(32'(flags[6]), 32'd1, "R8 completion sets TC");
        bytes(1);
        chk(32'(flags[7:6]), 32'b01, "R6 byte at zero count ignored");
        wr(2'd0, 32'h8);
        chk(32'(flags[6]), 32'd0, "R8 STOP request clears TC");
        chk(32'(stop_req), 32'd1, "R10 stop pulse");
        // R2: strobe bits read back as 0
        idle(); reg_addr = 2'd0; #1; chk(reg_rdata, 32'd0, "R2 strobes read 0");

        // R7: reload segment
        wr(2'd0, 32'h1);
        wr(2'd1, 32'd2);
        bytes(2);
        chk(32'(flags[7]), 32'd1, "R7 reload completion");
        chk(32'(flags[6]), 32'd0, "R7 TC stays low in reload");
        wr(2'd1, 32'd0);
        chk(32'(flags[7]), 32'd1, "R7 zero count keeps flag");
        wr(2'd0, 32'h5);
        chk(32'(flags[7]), 32'd1, "R7 START keeps flag");
        wr(2'd1, 32'd4);
        chk(32'(flags[7]), 32'd0, "R7 nonzero count clears");

        // R9: automatic end
        wr(2'd0, 32'h2);
        wr(2'd1, 32'd1);
        bytes(1);
        chk(32'(stop_req), 32'd1, "R9 auto STOP");
        chk(32'(flags[6]), 32'd0, "R9 TC stays low");

        // R11: TC set and START request together
        wr(2'd0, 32'h0);
        wr(2'd1, 32'd1);
        idle(); ev_byte_done = 1; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 32'h4; step(); idle();
        chk(32'(flags[6]), 32'd1, "R11 TC set beats START clear");

        // R3/R4/R11: write-one clears
        idle(); ev_misplaced = 1; ev_stop_seen = 1; step(); idle();
        chk(32'(flags[8]), 32'd1, "R3 misplaced sets");
        wr(2'd2, 32'h100);
        chk(32'(flags[8]), 32'd0, "R3 clear bit 8");
        chk(32'(flags[5]), 32'd1, "R4 other flags untouched");
        idle(); ev_nack = 1; reg_wr = 1; reg_addr = 2'd2; reg_wdata = 32'h10; step(); idle();
        chk(32'(flags[4]), 32'd1, "R11 NACK set beats clear");
        wr(2'd2, 32'h30);
        chk(32'(flags[5:4]), 32'd0, "R4 clear bits 5 and 4");

        // R12: disable
        idle(); ev_addr_hit = 1; ev_misplaced = 1; step(); idle();
        per_en = 0; ev_nack = 1; step(); idle();
        chk(32'({flags[8], flags[5:3]}), 32'd0, "R12 disable forces zero");
        per_en = 1;

        // R5: received byte
        idle(); ev_rx_valid = 1; ev_rx_data = 8'hA5; step(); idle();
        chk(32'(flags[2]), 32'd1, "R5 receive sets flag");
        reg_rd = 1; reg_addr = 2'd2; step(); idle();
        chk(32'(flags[2]), 32'd1, "R5 other read keeps flag");
        reg_rd = 1; reg_addr = 2'd3; #1;
        chk(reg_rdata, 32'hA5, "R5 data read");
        step(); idle();
        chk(32'(flags[2]), 32'd0, "R5 read clears flag");

        // Random traffic
        for (int c = 0; c < 4000; c++) begin
            int op;
            idle();
            per_en       = ($urandom % 25) != 0;
            ev_misplaced = ($urandom % 9) == 0;
            ev_stop_seen = ($urandom % 9) == 0;
            ev_nack      = ($urandom % 9) == 0;
            ev_addr_hit  = ($urandom % 9) == 0;
            ev_rx_valid  = ($urandom % 6) == 0;
            ev_rx_data   = 8'($urandom);
            ev_byte_done = ($urandom % 3) == 0;
            reg_addr     = 2'($urandom);
            op = int'($urandom % 8);
            case (op)
                0: begin
                    reg_wr = 1; reg_addr = 2'd0; reg_wdata = 32'($urandom % 4);
                    if ($urandom % 4 == 0) reg_wdata[2] = 1'b1;
                    if ($urandom % 5 == 0) reg_wdata[3] = 1'b1;
                end
                1: begin reg_wr = 1; reg_addr = 2'd1; reg_wdata = 32'($urandom % 4); end
                2: begin reg_wr = 1; reg_addr = 2'd2; reg_wdata = 32'($urandom % 4096); end
                3: begin reg_rd = 1; reg_addr = 2'd3; end
                4: begin reg_rd = 1; end
                default: ;
            endcase
            step();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule